// File: doc/BRIEF.md
# Multi-Purpose Output Selector with Request-to-Send Control

This block drives the multi-purpose output pin of each serial channel and keeps the request-to-send line for that channel. A three-bit select register per channel chooses which of eight internal signals reaches the pin: the request-to-send line, the counter/timer output, the transmit 1x and 16x clocks, the receive 1x and 16x clocks, transmitter ready, and receiver ready/FIFO full. Clocks, FIFOs, serial engines and the counter/timer live elsewhere. Their signals and status flags arrive here as inputs.

Request-to-send is active low. The host raises and drops it with command codes written to the channel's command input. Two mode inputs arm automatic negation. One negates the line while the receive FIFO and the receive shift register are both full, and releases it when they are no longer full. The other cancels the asserted state once the transmitter has fully drained, which means both the holding register and the shift register are empty.

Top module: `mpo_rts_top`

## Requirements
- R1: After synchronous reset, every channel's select is 0 (request-to-send), rts_n is 1, and mpo is 1.
- R2: The select field is 3 bits and is loaded by cfg_we at the next clock edge. mpo then follows the chosen source combinationally. The codes are 0 = rts_n, 1 = ct_out, 2 = tx_c1x, 3 = tx_c16x, 4 = rx_c1x, 5 = rx_c16x, 6 = tx_rdy, 7 = rx_rdy_full.
- R3: A command with code 4'h8 drives rts_n to 0 in the cycle after the edge that samples it, unless the receiver-full blocking of R6 applies.
- R4: A command with code 4'h9 drives rts_n to 1 in the cycle after the edge that samples it.
- R5: Command codes other than 4'h8 and 4'h9 leave rts_n unchanged.
- R6: When rx_auto is 1 and rx_fifo_full and rx_shift_full are both 1, rts_n is 1. When either flag drops, rts_n goes back to 0, but only if no 4'h9 command has been given since the last 4'h8.
- R7: When rx_auto is 0, the receiver-full flags have no effect on rts_n.
- R8: When tx_auto is 1, the edge at which tx_shift_empty AND tx_hold_empty turns from 0 to 1 cancels the asserted state. rts_n is then 1 and stays 1 until the next 4'h8 command.
- R9: If only one of tx_shift_empty and tx_hold_empty is 1, automatic transmit negation does not happen.
- R10: A 4'h8 command sampled at the same edge as a transmit-drain event wins, and rts_n becomes 0.
- R11: Channels are independent. A command on one channel does not change rts_n of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | NUM_CH | Per-channel select write enable |
| cfg_sel | input | 3*NUM_CH | Per-channel select value, channel c at bits [3c+2:3c] |
| cmd_valid | input | NUM_CH | Per-channel command strobe |
| cmd_code | input | 4*NUM_CH | Per-channel command code, channel c at bits [4c+3:4c] |
| rx_auto | input | NUM_CH | Arms receiver-full negation |
| tx_auto | input | NUM_CH | Arms transmitter-drain negation |
| rx_fifo_full | input | NUM_CH | Receive FIFO full |
| rx_shift_full | input | NUM_CH | Receive shift register holds a character |
| tx_shift_empty | input | NUM_CH | Transmit shift register empty |
| tx_hold_empty | input | NUM_CH | Transmit holding register empty |
| ct_out | input | 1 | Counter/timer output, shared by the channels |
| tx_c1x | input | NUM_CH | Transmit 1x clock |
| tx_c16x | input | NUM_CH | Transmit 16x clock |
| rx_c1x | input | NUM_CH | Receive 1x clock |
| rx_c16x | input | NUM_CH | Receive 16x clock |
| tx_rdy | input | NUM_CH | Transmitter ready status |
| rx_rdy_full | input | NUM_CH | Receiver ready / FIFO full status |
| rts_n | output | NUM_CH | Request-to-send, active low, registered |
| mpo | output | NUM_CH | Multi-purpose output pin |

## Verification
The assertions assume that the status flags, commands and select writes are stable around the rising edge. They also assume that a drain event is a 0-to-1 change of the combined empty flags. The bench changes every input two time units after a falling edge, holds each command strobe for exactly one cycle, and moves the empty and full flags one at a time. This way each edge sees one well-defined event, or a deliberately chosen pair of events for the priority case.

// File: rtl/mpo_pkg.sv
package mpo_pkg;

    // Output source codes; the order is part of the register encoding
    typedef enum logic [2:0] {
        SEL_RTS      = 3'd0,
        SEL_CT       = 3'd1,
        SEL_TX1X     = 3'd2,
        SEL_TX16X    = 3'd3,
        SEL_RX1X     = 3'd4,
        SEL_RX16X    = 3'd5,
        SEL_TXRDY    = 3'd6,
        SEL_RXRDYFUL = 3'd7
    } mpo_sel_e;

    localparam int CMD_W = 4;
    localparam logic [CMD_W-1:0] CMD_RTS_ON  = 4'h8;
    localparam logic [CMD_W-1:0] CMD_RTS_OFF = 4'h9;

    typedef struct packed {
        logic rts_n;
        logic ct_out;
        logic tx_c1x;
        logic tx_c16x;
        logic rx_c1x;
        logic rx_c16x;
        logic tx_rdy;
        logic rx_rdy_full;
    } mpo_src_t;

    typedef struct packed {
        logic req;       // host wants RTS asserted
        logic tx_idle;   // drain flags as seen at the previous edge
        logic rts_n;     // registered pin value
    } rts_state_t;

    function automatic logic mpo_pick(mpo_sel_e sel, mpo_src_t s);
        case (sel)
            SEL_RTS:      return s.rts_n;
            SEL_CT:       return s.ct_out;
            SEL_TX1X:     return s.tx_c1x;
            SEL_TX16X:    return s.tx_c16x;
            SEL_RX1X:     return s.rx_c1x;
            SEL_RX16X:    return s.rx_c16x;
            SEL_TXRDY:    return s.tx_rdy;
            default:      return s.rx_rdy_full;
        endcase
    endfunction

endpackage

// File: rtl/mpo_rts_ctrl.sv
module mpo_rts_ctrl
    import mpo_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_code,
    input  logic             rx_auto,
    input  logic             tx_auto,
    input  logic             rx_fifo_full,
    input  logic             rx_shift_full,
    input  logic             tx_shift_empty,
    input  logic             tx_hold_empty,
    output logic             rts_n
);

    rts_state_t st_q, st_d;
    logic cmd_on, cmd_off, tx_idle, tx_fire, rx_block;

    assign cmd_on   = cmd_valid && (cmd_code == CMD_RTS_ON);
    assign cmd_off  = cmd_valid && (cmd_code == CMD_RTS_OFF);
    assign tx_idle  = tx_shift_empty && tx_hold_empty;
    assign tx_fire  = tx_auto && tx_idle && !st_q.tx_idle;
    assign rx_block = rx_auto && rx_fifo_full && rx_shift_full;

    always_comb begin
        st_d = st_q;
        if (tx_fire) st_d.req = 1'b0;
        if (cmd_off) st_d.req = 1'b0;
        if (cmd_on)  st_d.req = 1'b1;   // host command outranks drain event
        st_d.tx_idle = tx_idle;
        st_d.rts_n   = !(st_d.req && !rx_block);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{req: 1'b0, tx_idle: 1'b1, rts_n: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign rts_n = st_q.rts_n;

    assert_cmd_on_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_on && !rx_block) |=> !rts_n);

    assert_cmd_off_R4: assert property (@(posedge clk) disable iff (rst)
        cmd_off |=> rts_n);

    assert_rx_block_R6: assert property (@(posedge clk) disable iff (rst)
        (rx_auto && rx_fifo_full && rx_shift_full) |=> rts_n);

    assert_tx_drain_R8: assert property (@(posedge clk) disable iff (rst)
        (tx_fire && !cmd_on) |=> rts_n);

    assert_cmd_wins_R10: assert property (@(posedge clk) disable iff (rst)
        (tx_fire && cmd_on && !rx_block) |=> !rts_n);

endmodule

// File: rtl/mpo_out_mux.sv
module mpo_out_mux
    import mpo_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_we,
    input  logic [2:0] cfg_sel,
    input  mpo_src_t   src,
    output logic       mpo
);

    mpo_sel_e sel_q;

    always_ff @(posedge clk) begin
        if (rst)         sel_q <= SEL_RTS;
        else if (cfg_we) sel_q <= mpo_sel_e'(cfg_sel);
    end

    assign mpo = mpo_pick(sel_q, src);

    assert_sel_load_R2: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (sel_q == mpo_sel_e'($past(cfg_sel))));

    assert_sel_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(sel_q));

endmodule

// File: rtl/mpo_rts_top.sv
module mpo_rts_top
    import mpo_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_CH-1:0]     cfg_we,
    input  logic [3*NUM_CH-1:0]   cfg_sel,
    input  logic [NUM_CH-1:0]     cmd_valid,
    input  logic [CMD_W*NUM_CH-1:0] cmd_code,
    input  logic [NUM_CH-1:0]     rx_auto,
    input  logic [NUM_CH-1:0]     tx_auto,
    input  logic [NUM_CH-1:0]     rx_fifo_full,
    input  logic [NUM_CH-1:0]     rx_shift_full,
    input  logic [NUM_CH-1:0]     tx_shift_empty,
    input  logic [NUM_CH-1:0]     tx_hold_empty,
    input  logic                  ct_out,
    input  logic [NUM_CH-1:0]     tx_c1x,
    input  logic [NUM_CH-1:0]     tx_c16x,
    input  logic [NUM_CH-1:0]     rx_c1x,
    input  logic [NUM_CH-1:0]     rx_c16x,
    input  logic [NUM_CH-1:0]     tx_rdy,
    input  logic [NUM_CH-1:0]     rx_rdy_full,
    output logic [NUM_CH-1:0]     rts_n,
    output logic [NUM_CH-1:0]     mpo
);

    localparam int SEL_W = 3;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        mpo_src_t src;

        mpo_rts_ctrl u_rts (
            .clk            (clk),
            .rst            (rst),
            .cmd_valid      (cmd_valid[c]),
            .cmd_code       (cmd_code[CMD_W*c +: CMD_W]),
            .rx_auto        (rx_auto[c]),
            .tx_auto        (tx_auto[c]),
            .rx_fifo_full   (rx_fifo_full[c]),
            .rx_shift_full  (rx_shift_full[c]),
            .tx_shift_empty (tx_shift_empty[c]),
            .tx_hold_empty  (tx_hold_empty[c]),
            .rts_n          (rts_n[c])
        );

        assign src = '{rts_n:       rts_n[c],
                       ct_out:      ct_out,
                       tx_c1x:      tx_c1x[c],
                       tx_c16x:     tx_c16x[c],
                       rx_c1x:      rx_c1x[c],
                       rx_c16x:     rx_c16x[c],
                       tx_rdy:      tx_rdy[c],
                       rx_rdy_full: rx_rdy_full[c]};

        mpo_out_mux u_mux (
            .clk     (clk),
            .rst     (rst),
            .cfg_we  (cfg_we[c]),
            .cfg_sel (cfg_sel[SEL_W*c +: SEL_W]),
            .src     (src),
            .mpo     (mpo[c])
        );
    end

endmodule

// File: tb/tb_mpo_rts_top.sv
module tb_mpo_rts_top;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH     = 2;
    localparam int WATCHDOG   = 5000;

    logic clk = 1'b0;
    logic rst;
    logic [NUM_CH-1:0]   cfg_we, cmd_valid, rx_auto, tx_auto;
    logic [NUM_CH-1:0]   rx_fifo_full, rx_shift_full, tx_shift_empty, tx_hold_empty;
    logic [3*NUM_CH-1:0] cfg_sel;
    logic [4*NUM_CH-1:0] cmd_code;
    logic                ct_out;
    logic [NUM_CH-1:0]   tx_c1x, tx_c16x, rx_c1x, rx_c16x, tx_rdy, rx_rdy_full;
    logic [NUM_CH-1:0]   rts_n, mpo;

    always #(CLK_PERIOD/2) clk = ~clk;

    mpo_rts_top #(.NUM_CH(NUM_CH)) dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .rx_auto(rx_auto), .tx_auto(tx_auto),
        .rx_fifo_full(rx_fifo_full), .rx_shift_full(rx_shift_full),
        .tx_shift_empty(tx_shift_empty), .tx_hold_empty(tx_hold_empty),
        .ct_out(ct_out), .tx_c1x(tx_c1x), .tx_c16x(tx_c16x),
        .rx_c1x(rx_c1x), .rx_c16x(rx_c16x), .tx_rdy(tx_rdy),
        .rx_rdy_full(rx_rdy_full), .rts_n(rts_n), .mpo(mpo)
    );

    typedef struct {
        int   ch;
        logic rts_n;
        logic mpo;
        int   req;
    } exp_t;

    exp_t q[$];
    exp_t e;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Monitor: compares on the falling edge, before the driver moves inputs
    always @(negedge clk) begin
        while (q.size() > 0) begin
            e = q.pop_front();
            checks++;
            if (rts_n[e.ch] !== e.rts_n || mpo[e.ch] !== e.mpo) begin
                errors++;
                $display("FAIL R%0d ch%0d rts_n=%b mpo=%b expected rts_n=%b mpo=%b",
                         e.req, e.ch, rts_n[e.ch], mpo[e.ch], e.rts_n, e.mpo);
            end
        end
    end

    task automatic drive_wait();
        @(negedge clk); #2;
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic expect_ch(int ch, logic r, logic m, int req);
        exp_t x;
        x.ch = ch; x.rts_n = r; x.mpo = m; x.req = req;
        q.push_back(x);
    endtask

    task automatic send_cmd(int ch, logic [3:0] c);
        drive_wait();
        cmd_valid[ch] = 1'b1;
        cmd_code[4*ch +: 4] = c;
        tick();
        cmd_valid[ch] = 1'b0;
    endtask

    task automatic write_sel(int ch, logic [2:0] s);
        drive_wait();
        cfg_we[ch] = 1'b1;
        cfg_sel[3*ch +: 3] = s;
        tick();
        cfg_we[ch] = 1'b0;
    endtask

    // Chosen source of channel 0 gets v, all others the opposite
    task automatic set_src0(int k, logic v);
        ct_out = ~v; tx_c1x[0] = ~v; tx_c16x[0] = ~v; rx_c1x[0] = ~v;
        rx_c16x[0] = ~v; tx_rdy[0] = ~v; rx_rdy_full[0] = ~v;
        case (k)
            1: ct_out = v;
            2: tx_c1x[0] = v;
            3: tx_c16x[0] = v;
            4: rx_c1x[0] = v;
            5: rx_c16x[0] = v;
            6: tx_rdy[0] = v;
            default: rx_rdy_full[0] = v;
        endcase
    endtask

    task automatic step0(logic r, logic m, int req);
        tick();
        expect_ch(0, r, m, req);
    endtask

    initial begin
        rst = 1'b1;
        cfg_we = '0; cmd_valid = '0; rx_auto = '0; tx_auto = '0;
        rx_fifo_full = '0; rx_shift_full = '0; tx_shift_empty = '0; tx_hold_empty = '0;
        cfg_sel = '0; cmd_code = '0; ct_out = 1'b0;
        tx_c1x = '0; tx_c16x = '0; rx_c1x = '0; rx_c16x = '0; tx_rdy = '0; rx_rdy_full = '0;
        repeat (3) @(posedge clk);
        drive_wait();
        rst = 1'b0;
        tick();
        // R1: reset state on both channels
        expect_ch(0, 1'b1, 1'b1, 1);
        expect_ch(1, 1'b1, 1'b1, 1);

        // R3: assert command; R11: other channel untouched
        send_cmd(0, 4'h8);
        expect_ch(0, 1'b0, 1'b0, 3);
        expect_ch(1, 1'b1, 1'b1, 11);

        // R2: sweep every source code with both polarities
        for (int s = 1; s < 8; s++) begin
            write_sel(0, 3'(s));
            for (int p = 0; p < 2; p++) begin
                drive_wait();
                set_src0(s, logic'(p));
                step0(1'b0, logic'(p), 2);
            end
        end
        write_sel(0, 3'd0);
        expect_ch(0, 1'b0, 1'b0, 2);

        // R5: unrelated command code leaves rts_n
        send_cmd(0, 4'h5);
        expect_ch(0, 1'b0, 1'b0, 5);
        send_cmd(0, 4'h1);
        expect_ch(0, 1'b0, 1'b0, 5);

        // R4: negate command; R11: channel 1 assert leaves channel 0
        send_cmd(0, 4'h9);
        expect_ch(0, 1'b1, 1'b1, 4);
        send_cmd(1, 4'h8);
        expect_ch(1, 1'b0, 1'b0, 11);
        expect_ch(0, 1'b1, 1'b1, 11);
        send_cmd(0, 4'h8);
        expect_ch(0, 1'b0, 1'b0, 3);

        // R6: receiver-full negation needs both flags, released when not full
        drive_wait(); rx_auto[0] = 1'b1; rx_fifo_full[0] = 1'b1;
        step0(1'b0, 1'b0, 6);
        drive_wait(); rx_shift_full[0] = 1'b1;
        step0(1'b1, 1'b1, 6);
        drive_wait(); rx_fifo_full[0] = 1'b0;
        step0(1'b0, 1'b0, 6);
        // R6: a negate command stays in force after the full condition clears
        drive_wait(); rx_fifo_full[0] = 1'b1;
        step0(1'b1, 1'b1, 6);
        send_cmd(0, 4'h9);
        expect_ch(0, 1'b1, 1'b1, 6);
        drive_wait(); rx_fifo_full[0] = 1'b0;
        step0(1'b1, 1'b1, 6);
        send_cmd(0, 4'h8);
        expect_ch(0, 1'b0, 1'b0, 3);

        // R7: unarmed, full flags have no effect
        drive_wait(); rx_auto[0] = 1'b0; rx_fifo_full[0] = 1'b1;
        step0(1'b0, 1'b0, 7);
        drive_wait(); rx_fifo_full[0] = 1'b0; rx_shift_full[0] = 1'b0;
        step0(1'b0, 1'b0, 7);

        // R9: only holding register empty does not negate
        drive_wait(); tx_auto[0] = 1'b1; tx_hold_empty[0] = 1'b1;
        step0(1'b0, 1'b0, 9);
        // R8: shift register drains too -> negated and stays so
        drive_wait(); tx_shift_empty[0] = 1'b1;
        step0(1'b1, 1'b1, 8);
        drive_wait(); tx_shift_empty[0] = 1'b0;
        step0(1'b1, 1'b1, 8);

        // R10: assert command at the same edge as a drain event wins
        drive_wait();
        tx_shift_empty[0] = 1'b1;
        cmd_valid[0] = 1'b1; cmd_code[3:0] = 4'h8;
        tick();
        cmd_valid[0] = 1'b0;
        expect_ch(0, 1'b0, 1'b0, 10);
        // R8: no new drain edge while staying empty
        step0(1'b0, 1'b0, 8);

        // R9: only shift register empty does not negate
        drive_wait(); tx_shift_empty[0] = 1'b0; tx_hold_empty[0] = 1'b0;
        step0(1'b0, 1'b0, 9);
        drive_wait(); tx_shift_empty[0] = 1'b1;
        step0(1'b0, 1'b0, 9);

        // R1: reset again returns negated RTS and RTS selection
        write_sel(0, 3'd6);
        drive_wait(); rst = 1'b1; tx_rdy[0] = 1'b0;
        tick();
        drive_wait(); rst = 1'b0;
        step0(1'b1, 1'b1, 1);

        drive_wait();
        @(negedge clk); #1;
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule